// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Array

This block is a row of small logic cells, each holding a sixteen-entry truth table addressed by four bits of a wide input vector. Any cell can merge its own table result with the result arriving from the cell to its left. The merge is either a logical AND or a logical OR. Running several cells together this way yields a single function of four times as many inputs as there are cells in the run. Cells are grouped eight to a block. A run of cells is not stopped at a block edge: the last cell of one block feeds the first cell of the next block in the row. A run of four cells therefore decodes a sixteen-bit address.

Each cell can present its merged result directly or through a flip-flop. The flip-flop has its own asynchronous clear and preset, and clear has priority over preset. Every cell's table and mode bits are loaded serially through one shift register. All outputs stay at zero until a complete load has finished.

The loader is a three-state machine with the states ST_BLANK, ST_SHIFT and ST_READY:

- ST_BLANK holds after reset.
- T_START moves ST_BLANK to ST_SHIFT on the first shifted bit.
- In ST_SHIFT, each cycle with the enable high counts one bit, and a cycle with the enable low is a pause.
- T_LAST moves ST_SHIFT to ST_READY on the final bit.
- T_RELOAD moves ST_READY back to ST_SHIFT when a new load begins.

Top module: `cascade_array`

## Requirements
- R1: Cell k takes its table index from data_in[4k+3:4k]. It looks up bit i of its 16-bit table for index i.
- R2: With the merge bit (word bit 16) at 0, a cell's merged result is its table bit ANDed with its cascade input.
- R3: With the merge bit at 1, a cell's merged result is its table bit ORed with its cascade input.
- R4: A cell whose run-start bit (word bit 17) is 1, and cell 0 in every case, uses the identity value as its cascade input instead of the left neighbour's result. The identity value is 1 for AND and 0 for OR. Every other cell takes the merged result of the cell to its left.
- R5: A run continues from cell 7 of one block into cell 0 of the next block, so that n cells compute a function of 4n inputs, for n from 1 to 16.
- R6: With the register bit (word bit 18) at 1, a cell's output is its merged result captured at the previous rising clock edge. With the register bit at 0, the output is the present merged result.
- R7: A cell's clear and preset act on its flip-flop at once, without waiting for the clock. Clear forces 0, preset forces 1, and clear wins when both are high.
- R8: A load is 19 bits per cell, sent while cfg_en is high, cell 0 first and each word least significant bit first. The word holds the table in bits 15:0 and the mode bits in 18:16. cfg_ready goes high after the 304th shifted bit.
- R9: While cfg_ready is low, chain_out and row_cas_out are zero. Raising cfg_en while ready drops cfg_ready and starts a fresh count.
- R10: A low cfg_en during a load pauses the count without losing bits. cfg_ready stays high while cfg_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for configuration |
| cfg_din | input | 1 | Serial configuration bit |
| data_in | input | 64 | Four table-index bits per cell |
| el_clr | input | 16 | Per-cell asynchronous register clear |
| el_pre | input | 16 | Per-cell asynchronous register preset |
| chain_out | output | 16 | Per-cell output (merged or registered) |
| row_cas_out | output | 1 | Merged result leaving the last cell of the row |
| cfg_ready | output | 1 | High once a full load has completed |

## Verification
On every cycle, the assertions check four things: outputs stay at zero before loading completes; readiness arises only from a shifted bit and survives idle cycles; clear beats preset on registered cells; and a run-start cell in combinational mode shows its own table bit. Only the bench's scenarios can show the rest. That covers cascading through long AND and OR runs, runs that cross the block seam, and every run length from one to sixteen cells. It also covers registered outputs lagging one edge behind their inputs, pausing a load mid-stream, and restarting a load from the ready state.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

    localparam int LUT_IN    = 4;
    localparam int TBL_W     = 1 << LUT_IN;
    localparam int OR_POS    = TBL_W;
    localparam int START_POS = TBL_W + 1;
    localparam int REG_POS   = TBL_W + 2;
    localparam int CFG_W     = TBL_W + 3;

    typedef struct packed {
        logic              use_reg;
        logic              chain_start;
        logic              or_mode;
        logic [TBL_W-1:0]  table_bits;
    } el_cfg_t;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_SHIFT = 2'd1,
        ST_READY = 2'd2
    } cfg_state_t;

endpackage

// File: rtl/le_cell.sv
module le_cell
    import cascade_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  el_cfg_t           cfg,
    input  logic [LUT_IN-1:0] din,
    input  logic              cas_in,
    input  logic              clr,
    input  logic              pre,
    output logic              cas_out,
    output logic              el_out
);

    logic lut_bit;
    logic cin_eff;
    logic q;

    always_comb begin
        lut_bit = cfg.table_bits[din];
        cin_eff = cfg.chain_start ? ~cfg.or_mode : cas_in;
        cas_out = cfg.or_mode ? (lut_bit | cin_eff) : (lut_bit & cin_eff);
    end

    always_ff @(posedge clk or negedge rst_n or posedge clr or posedge pre) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (clr) begin
            q <= 1'b0;
        end else if (pre) begin
            q <= 1'b1;
        end else begin
            q <= cas_out;
        end
    end

    always_comb begin
        el_out = enable & (cfg.use_reg ? q : cas_out);
    end

endmodule

// File: rtl/le_block.sv
module le_block
    import cascade_pkg::*;
#(
    parameter int PER_BLOCK = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic [PER_BLOCK*CFG_W-1:0]  cfg_bits,
    input  logic [PER_BLOCK*LUT_IN-1:0] din,
    input  logic [PER_BLOCK-1:0]        clr,
    input  logic [PER_BLOCK-1:0]        pre,
    input  logic                        cas_in,
    output logic                        cas_out,
    output logic [PER_BLOCK-1:0]        el_out
);

    logic [PER_BLOCK:0] link;

    assign link[0] = cas_in;
    assign cas_out = link[PER_BLOCK];

    for (genvar e = 0; e < PER_BLOCK; e++) begin : g_cell
        le_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (enable),
            .cfg     (el_cfg_t'(cfg_bits[e*CFG_W +: CFG_W])),
            .din     (din[e*LUT_IN +: LUT_IN]),
            .cas_in  (link[e]),
            .clr     (clr[e]),
            .pre     (pre[e]),
            .cas_out (link[e+1]),
            .el_out  (el_out[e])
        );
    end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cascade_pkg::*;
#(
    parameter int TOTAL = 304
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic [TOTAL-1:0] cfg_bits,
    output logic             ready
);

    localparam int CNT_W = $clog2(TOTAL + 1);

    cfg_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [TOTAL-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            ST_BLANK, ST_READY: begin
                if (cfg_en) begin
                    state_d = ST_SHIFT;
                    count_d = CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                if (cfg_en) begin
                    if (count_q == CNT_W'(TOTAL - 1)) begin
                        state_d = ST_READY;
                        count_d = '0;
                    end else begin
                        count_d = count_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_BLANK;
                count_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (cfg_en) begin
            shreg <= {cfg_din, shreg[TOTAL-1:1]};
        end
    end

    always_comb begin
        ready    = (state_q == ST_READY);
        cfg_bits = shreg;
    end

endmodule

// File: rtl/cascade_array.sv
module cascade_array
    import cascade_pkg::*;
#(
    parameter int BLOCKS    = 2,
    parameter int PER_BLOCK = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_en,
    input  logic                                cfg_din,
    input  logic [BLOCKS*PER_BLOCK*LUT_IN-1:0]  data_in,
    input  logic [BLOCKS*PER_BLOCK-1:0]         el_clr,
    input  logic [BLOCKS*PER_BLOCK-1:0]         el_pre,
    output logic [BLOCKS*PER_BLOCK-1:0]         chain_out,
    output logic                                row_cas_out,
    output logic                                cfg_ready
);

    localparam int NUM_EL  = BLOCKS * PER_BLOCK;
    localparam int TOTAL   = NUM_EL * CFG_W;
    localparam int BLK_CFG = PER_BLOCK * CFG_W;
    localparam int BLK_DIN = PER_BLOCK * LUT_IN;

    logic [TOTAL-1:0] cfg_bits;
    logic [BLOCKS:0]  bc;

    cfg_loader #(.TOTAL(TOTAL)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_bits (cfg_bits),
        .ready    (cfg_ready)
    );

    assign bc[0] = ~cfg_bits[OR_POS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        le_block #(.PER_BLOCK(PER_BLOCK)) u_blk (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (cfg_ready),
            .cfg_bits (cfg_bits[b*BLK_CFG +: BLK_CFG]),
            .din      (data_in[b*BLK_DIN +: BLK_DIN]),
            .clr      (el_clr[b*PER_BLOCK +: PER_BLOCK]),
            .pre      (el_pre[b*PER_BLOCK +: PER_BLOCK]),
            .cas_in   (bc[b]),
            .cas_out  (bc[b+1]),
            .el_out   (chain_out[b*PER_BLOCK +: PER_BLOCK])
        );
    end

    assign row_cas_out = cfg_ready & bc[BLOCKS];

endmodule

// File: rtl/cascade_array_chk.sv
module cascade_array_chk
    import cascade_pkg::*;
#(
    parameter int NUM_EL = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_en,
    input logic                     cfg_ready,
    input logic [NUM_EL*LUT_IN-1:0] data_in,
    input logic [NUM_EL-1:0]        el_clr,
    input logic [NUM_EL-1:0]        el_pre,
    input logic [NUM_EL-1:0]        chain_out,
    input logic                     row_cas_out,
    input logic [NUM_EL*CFG_W-1:0]  cfg_bits
);

    p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |-> (chain_out == '0 && !row_cas_out));

    p_ready_from_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_ready) |-> $past(cfg_en));

    p_ready_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && !cfg_en) |=> cfg_ready);

    for (genvar k = 0; k < NUM_EL; k++) begin : g_el
        p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_ready && cfg_bits[k*CFG_W + REG_POS] && el_clr[k])
            |-> !chain_out[k]);

        p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_ready && cfg_bits[k*CFG_W + REG_POS] && el_pre[k] && !el_clr[k])
            |-> chain_out[k]);

        p_start_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_ready && !cfg_bits[k*CFG_W + REG_POS]
             && (k == 0 || cfg_bits[k*CFG_W + START_POS]))
            |-> chain_out[k] == cfg_bits[k*CFG_W + int'(data_in[k*LUT_IN +: LUT_IN])]);
    end

endmodule

bind cascade_array cascade_array_chk #(.NUM_EL(NUM_EL)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_ready   (cfg_ready),
    .data_in     (data_in),
    .el_clr      (el_clr),
    .el_pre      (el_pre),
    .chain_out   (chain_out),
    .row_cas_out (row_cas_out),
    .cfg_bits    (cfg_bits)
);

// File: tb/test_cascade_array.sv
`timescale 1ns/1ps
module test_cascade_array;

    localparam int NE    = 16;
    localparam int WW    = 19;
    localparam int TOTAL = NE * WW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic          cfg_din = 1'b0;
    logic [NE*4-1:0] data_in = '0;
    logic [NE-1:0] el_clr = '0;
    logic [NE-1:0] el_pre = '0;
    logic [NE-1:0] chain_out;
    logic          row_cas_out;
    logic          cfg_ready;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] tbl [NE];
    bit          orm [NE];
    bit          st  [NE];
    bit          ur  [NE];

    always #10 clk = ~clk;

    cascade_array i_cascade_array (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .data_in(data_in), .el_clr(el_clr), .el_pre(el_pre),
        .chain_out(chain_out), .row_cas_out(row_cas_out), .cfg_ready(cfg_ready)
    );

    task automatic check(input string req, input logic [NE:0] act, input logic [NE:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20ns * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // merged result of every cell for a given data vector
    function automatic logic [NE-1:0] casc_vec(input logic [NE*4-1:0] d);
        logic [NE-1:0] r;
        logic prev = 1'b0;
        for (int e = 0; e < NE; e++) begin
            logic cin, lb;
            cin  = (e == 0 || st[e]) ? !orm[e] : prev;
            lb   = tbl[e][d[4*e +: 4]];
            prev = orm[e] ? (lb | cin) : (lb & cin);
            r[e] = prev;
        end
        return r;
    endfunction

    function automatic logic [NE:0] model(input logic [NE*4-1:0] d, input logic [NE-1:0] regv);
        logic [NE-1:0] c, o;
        c = casc_vec(d);
        for (int e = 0; e < NE; e++) o[e] = ur[e] ? regv[e] : c[e];
        return {c[NE-1], o};
    endfunction

    task automatic load(input bit do_pause);
        logic [TOTAL-1:0] bits;
        for (int e = 0; e < NE; e++)
            bits[e*WW +: WW] = {ur[e], st[e], orm[e], tbl[e]};
        for (int i = 0; i < TOTAL; i++) begin
            cfg_din = bits[i];
            cfg_en  = 1'b1;
            @(negedge clk);
            if (i == 0) check("R9 first bit drops ready", {row_cas_out, chain_out} | (cfg_ready << NE), '0);
            if (i == TOTAL - 2) check("R8 not ready before last bit", {16'b0, cfg_ready}, '0);
            if (do_pause && i == TOTAL / 2) begin
                cfg_en = 1'b0;
                repeat (5) @(negedge clk);
                check("R10 pause keeps loading", {cfg_ready, chain_out}, '0);
            end
        end
        cfg_en = 1'b0;
        #1;
        check("R8 ready after full load", {16'b0, cfg_ready}, 17'd1);
    endtask

    // combinational check then registered check with changed data
    task automatic data_pair(input string req, input logic [NE*4-1:0] d1, input logic [NE*4-1:0] d2);
        logic [NE-1:0] rv;
        data_in = d1;
        @(posedge clk);
        rv = casc_vec(d1);
        #2;
        check({req, " R1 outputs"}, {row_cas_out, chain_out}, model(d1, rv));
        data_in = d2;
        #1;
        check({req, " R6 register lag"}, {row_cas_out, chain_out}, model(d2, rv));
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] addr;
        logic [NE*4-1:0] d;
        repeat (3) @(negedge clk);
        check("R9 reset outputs", {row_cas_out, chain_out}, '0);
        check("R9 reset ready", {16'b0, cfg_ready}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        void'($urandom(32'h5eed_1234));

        // 16-bit decode with four AND cells
        addr = 16'hA5C3;
        for (int e = 0; e < NE; e++) begin
            tbl[e] = (e < 4) ? (16'h1 << addr[4*e +: 4]) : 16'h0;
            orm[e] = 1'b0; st[e] = (e >= 4); ur[e] = 1'b0;
        end
        load(1'b1);
        data_in = {48'h0, addr};
        #1;
        check("R2 address match", {16'b0, chain_out[3]}, 17'd1);
        check("R2 address chain", {row_cas_out, chain_out}, model(data_in, '0));
        data_in = {48'h0, addr ^ 16'h0100};
        #1;
        check("R2 address mismatch", {16'b0, chain_out[3]}, 17'd0);

        // OR run over the block seam, cells 6..9
        for (int e = 0; e < NE; e++) begin
            tbl[e] = (e == 6) ? 16'h0001 : 16'h0;
            orm[e] = (e >= 6 && e <= 9); st[e] = (e == 6 || e == 10); ur[e] = 1'b0;
        end
        load(1'b0);
        data_in = {NE{4'hF}};
        data_in[24 +: 4] = 4'h0;
        #1;
        check("R5 OR crosses seam", {16'b0, chain_out[9]}, 17'd1);
        check("R3 OR chain", {row_cas_out, chain_out}, model(data_in, '0));
        data_in[24 +: 4] = 4'h3;
        #1;
        check("R5 OR seam false", {16'b0, chain_out[9]}, 17'd0);

        // every run length 1..16 with random tables and modes
        for (int it = 0; it < 20; it++) begin
            int len;
            bit m;
            len = (it % NE) + 1;
            m = 1'b0;
            for (int e = 0; e < NE; e++) begin
                if (e % len == 0) m = $urandom_range(0, 1);
                st[e]  = (e % len == 0) ? 1'b1 : ($urandom_range(0, 15) == 0);
                orm[e] = m;
                ur[e]  = $urandom_range(0, 1);
                tbl[e] = m ? (16'($urandom) & 16'($urandom)) : (16'($urandom) | 16'($urandom));
            end
            load(it == 7);
            for (int v = 0; v < 6; v++) begin
                logic [NE*4-1:0] a, b;
                a = {$urandom, $urandom};
                b = {$urandom, $urandom};
                data_pair("R2 R3 R4 R5 random", a, b);
            end
        end

        // asynchronous clear and preset, all cells registered
        for (int e = 0; e < NE; e++) begin
            ur[e] = 1'b1; orm[e] = 1'b0; st[e] = 1'b1; tbl[e] = 16'($urandom);
        end
        load(1'b0);
        d = {$urandom, $urandom};
        data_in = d;
        el_pre = '1;
        #1;
        check("R7 preset", {1'b0, chain_out}, {1'b0, 16'hFFFF});
        el_clr = 16'h00FF;
        #1;
        check("R7 clear wins", {1'b0, chain_out}, {1'b0, 16'hFF00});
        @(negedge clk);
        el_clr = '0;
        el_pre = '0;
        @(posedge clk);
        #2;
        check("R7 release then capture", {1'b0, chain_out}, {1'b0, casc_vec(d)});

        // restart from ready
        @(negedge clk);
        for (int e = 0; e < NE; e++) begin
            ur[e] = 1'b0; tbl[e] = 16'($urandom);
        end
        load(1'b0);
        data_in = {$urandom, $urandom};
        #1;
        check("R9 reload result", {row_cas_out, chain_out}, model(data_in, '0));

        finish_run();
    end

endmodule